// File: doc/BRIEF.md
# Counted-Enable Interrupt Pending Aggregator

This block watches a fixed set of interrupt sources. Each source has a level request line and several separate enable contributions, and it reduces them to one CPU interrupt request and one vector. A source counts as enabled only when all of its contributors are on. The block tracks this as a small per-source counter that is compared against a per-source maximum fixed at elaboration. The register block outside this design reports each enable or disable as a single event that names a source index. An event can also name a group entry. In that case the change travels along a static member chain, so one event can adjust several sources.

Among the sources that are both requesting and fully enabled, the one with the lowest index supplies the vector. Selection uses index order only. The CPU's 4-bit interrupt mask can suppress the vector: when the mask is all ones, no vector is offered. The request line is not affected by the mask. The request line, the vector and its valid flag are registered. They reflect the levels and the event sampled at the same clock edge.

Top module: `intc_pending_agg`

## Requirements
- R1: Source i (i ≥ 1, with a non-zero vector entry) is pending when its level line is high and its enable count equals its configured maximum. A maximum of 0 means the source is always enabled. Index 0 and entries with a zero vector are never pending.
- R2: `irq_out` is high in the cycle after an edge exactly when at least one source is pending, computed from the levels and the event sampled at that edge.
- R3: When `vec_valid` is high, `vec_out` holds the vector entry of the lowest-index pending source. When `vec_valid` is low, `vec_out` is 0.
- R4: If `imask` sampled at the edge equals 4'hF, `vec_valid` is low and `irq_out` is unaffected.
- R5: Holding a level line at its current value causes no change in pending state or outputs.
- R6: An event with `ev_on`=1 adds one to the target's count and saturates at its maximum. An event with `ev_on`=0 subtracts one and saturates at 0. Only targets with a non-zero vector have a count.
- R7: After adjusting a target, the event moves to the target's link entry when that link is non-zero and either `ev_group` is 1 or the target's vector is zero. Every later member is treated as a group step. Each source on the walk is adjusted at most once.
- R8: An event aimed at index 0 is ignored. So is an event at an index that has no link and either a zero vector or a zero maximum; the walk also stops at such an index.
- R9: After synchronous reset, all counts are 0 and `irq_out`, `vec_valid` and `vec_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Level request per source |
| ev_valid | input | 1 | An enable-change event is present this cycle |
| ev_id | input | IDW | Target index of the event |
| ev_on | input | 1 | 1 = enable (+1), 0 = disable (-1) |
| ev_group | input | 1 | Treat the target as a group step |
| imask | input | 4 | CPU interrupt mask level |
| irq_out | output | 1 | CPU interrupt request |
| vec_valid | output | 1 | A vector is offered |
| vec_out | output | VEC_W | Vector of the selected source |

## Verification
The bench builds the block with its default eight-entry configuration. In that configuration index 0 and index 6 are reserved. Source 4 has a maximum of 0. Sources 1, 2 and 3 need two contributors and source 7 needs three. Index 5 is a vector-less group head whose chain runs 5→2→3. These values bring saturation at both ends, propagation through a vector-less head, a direct event that must stop at a linked member, ignored reserved targets and lowest-index selection among several pending sources within reach of short random runs.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        logic hit;
        dir_e dir;
    } adj_t;

    function automatic logic count_full(input int cnt, input int max);
        return cnt == max;
    endfunction

endpackage

// File: rtl/intc_chain_walk.sv
module intc_chain_walk #(
    parameter int NUM_SRC = 8,
    parameter int IDW     = 3,
    parameter int VEC_W   = 12,
    parameter int CNT_W   = 2,
    parameter logic [NUM_SRC*VEC_W-1:0] VEC_TABLE  = '0,
    parameter logic [NUM_SRC*CNT_W-1:0] MAX_TABLE  = '0,
    parameter logic [NUM_SRC*IDW-1:0]   LINK_TABLE = '0
) (
    input  logic               ev_valid,
    input  logic [IDW-1:0]     ev_id,
    input  logic               ev_group,
    output logic [NUM_SRC-1:0] hit
);
    logic [IDW-1:0]   cur;
    logic             go;
    logic             grp;
    logic [VEC_W-1:0] vec;
    logic [CNT_W-1:0] mx;
    logic [IDW-1:0]   lnk;

    always_comb begin
        hit = '0;
        cur = ev_id;
        go  = ev_valid && (ev_id != '0);
        grp = ev_group;
        vec = '0;
        mx  = '0;
        lnk = '0;
        for (int step = 0; step < NUM_SRC; step++) begin
            if (go) begin
                vec = VEC_TABLE[int'(cur)*VEC_W +: VEC_W];
                mx  = MAX_TABLE[int'(cur)*CNT_W +: CNT_W];
                lnk = LINK_TABLE[int'(cur)*IDW +: IDW];
                if ((lnk == '0) && ((mx == '0) || (vec == '0))) begin
                    go = 1'b0;
                end else begin
                    if (vec != '0) hit[cur] = 1'b1;
                    if ((grp || (vec == '0)) && (lnk != '0)) begin
                        cur = lnk;
                        grp = 1'b1;
                    end else begin
                        go = 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/intc_enable_ctr.sv
module intc_enable_ctr
    import intc_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter logic [CNT_W-1:0] MAX = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  adj_t             adj,
    output logic [CNT_W-1:0] cnt_q,
    output logic             full_nxt
);
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (adj.hit) begin
            if (adj.dir == DIR_UP && cnt_q < MAX)
                cnt_nxt = cnt_q + 1'b1;
            else if (adj.dir == DIR_DOWN && cnt_q != '0)
                cnt_nxt = cnt_q - 1'b1;
        end
        full_nxt = count_full(int'(cnt_nxt), int'(MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/intc_pick_lowest.sv
module intc_pick_lowest #(
    parameter int NUM_SRC = 8,
    parameter int IDW     = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDW-1:0]     idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_pending_agg.sv
module intc_pending_agg
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDW     = $clog2(NUM_SRC),
    parameter int VEC_W   = 12,
    parameter int CNT_W   = 2,
    parameter logic [NUM_SRC*VEC_W-1:0] VEC_TABLE =
        {12'h4E0, 12'h000, 12'h000, 12'h460, 12'h440, 12'h420, 12'h400, 12'h000},
    parameter logic [NUM_SRC*CNT_W-1:0] MAX_TABLE =
        {2'd3, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd0},
    parameter logic [NUM_SRC*IDW-1:0] LINK_TABLE =
        {3'd0, 3'd0, 3'd2, 3'd0, 3'd0, 3'd3, 3'd0, 3'd0}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               ev_valid,
    input  logic [IDW-1:0]     ev_id,
    input  logic               ev_on,
    input  logic               ev_group,
    input  logic [3:0]         imask,
    output logic               irq_out,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    localparam logic [3:0] MASK_ALL = 4'hF;

    logic [NUM_SRC-1:0]       hit;
    logic [NUM_SRC-1:0]       full_nxt;
    logic [NUM_SRC-1:0]       pend_nxt;
    logic [NUM_SRC*CNT_W-1:0] cnt_flat;
    logic                     found;
    logic [IDW-1:0]           sel_idx;

    intc_chain_walk #(
        .NUM_SRC(NUM_SRC), .IDW(IDW), .VEC_W(VEC_W), .CNT_W(CNT_W),
        .VEC_TABLE(VEC_TABLE), .MAX_TABLE(MAX_TABLE), .LINK_TABLE(LINK_TABLE)
    ) u_walk (
        .ev_valid (ev_valid),
        .ev_id    (ev_id),
        .ev_group (ev_group),
        .hit      (hit)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [VEC_W-1:0] SRC_VEC = VEC_TABLE[g*VEC_W +: VEC_W];
        adj_t adj;
        assign adj.hit = hit[g];
        assign adj.dir = ev_on ? DIR_UP : DIR_DOWN;

        intc_enable_ctr #(
            .CNT_W (CNT_W),
            .MAX   (MAX_TABLE[g*CNT_W +: CNT_W])
        ) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .adj      (adj),
            .cnt_q    (cnt_flat[g*CNT_W +: CNT_W]),
            .full_nxt (full_nxt[g])
        );

        if (g == 0 || SRC_VEC == '0) begin : g_none
            assign pend_nxt[g] = 1'b0;
        end else begin : g_live
            assign pend_nxt[g] = src_level[g] & full_nxt[g];
        end
    end

    intc_pick_lowest #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_pick (
        .req   (pend_nxt),
        .found (found),
        .idx   (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out   <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            irq_out <= found;
            if (found && imask != MASK_ALL) begin
                vec_valid <= 1'b1;
                vec_out   <= VEC_TABLE[int'(sel_idx)*VEC_W +: VEC_W];
            end else begin
                vec_valid <= 1'b0;
                vec_out   <= '0;
            end
        end
    end
endmodule

// File: rtl/intc_pending_agg_chk.sv
module intc_pending_agg_chk #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 12,
    parameter int CNT_W   = 2,
    parameter logic [NUM_SRC*CNT_W-1:0] MAX_TABLE = '0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_SRC-1:0]       src_level,
    input logic [3:0]               imask,
    input logic                     irq_out,
    input logic                     vec_valid,
    input logic [VEC_W-1:0]         vec_out,
    input logic [NUM_SRC*CNT_W-1:0] cnt_flat
);
    function automatic logic counts_in_range(input logic [NUM_SRC*CNT_W-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NUM_SRC; i++)
            if (c[i*CNT_W +: CNT_W] > MAX_TABLE[i*CNT_W +: CNT_W]) ok = 1'b0;
        return ok;
    endfunction

    p_quiet_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_level) == '0) |-> !irq_out);

    p_valid_needs_irq_r3: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> irq_out);

    p_idle_vec_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> vec_out == '0);

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(imask) == 4'hF) |-> !vec_valid);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        counts_in_range(cnt_flat));

    p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && !vec_valid && cnt_flat == '0));
endmodule

bind intc_pending_agg intc_pending_agg_chk #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .CNT_W(CNT_W), .MAX_TABLE(MAX_TABLE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_level (src_level),
    .imask     (imask),
    .irq_out   (irq_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .cnt_flat  (cnt_flat)
);

// File: tb/test_intc_pending_agg.sv
module test_intc_pending_agg;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  src_level = '0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_id = '0;
    logic        ev_on = 1'b0;
    logic        ev_group = 1'b0;
    logic [3:0]  imask = '0;
    logic        irq_out;
    logic        vec_valid;
    logic [11:0] vec_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    int m_vec  [N] = '{12'h000, 12'h400, 12'h420, 12'h440, 12'h460, 12'h000, 12'h000, 12'h4E0};
    int m_max  [N] = '{0, 2, 2, 2, 0, 0, 0, 3};
    int m_link [N] = '{0, 0, 3, 0, 0, 2, 0, 0};
    int m_cnt  [N];

    intc_pending_agg i_intc_pending_agg (
        .clk(clk), .rst(rst), .src_level(src_level), .ev_valid(ev_valid),
        .ev_id(ev_id), .ev_on(ev_on), .ev_group(ev_group), .imask(imask),
        .irq_out(irq_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic void model_event(input int id, input bit on, input bit grp);
        int cur;
        bit go;
        bit g;
        cur = id;
        go = (id != 0);
        g = grp;
        for (int k = 0; k < N; k++) begin
            if (go) begin
                if (m_link[cur] == 0 && (m_max[cur] == 0 || m_vec[cur] == 0)) begin
                    go = 0;
                end else begin
                    if (m_vec[cur] != 0) begin
                        if (on && m_cnt[cur] < m_max[cur]) m_cnt[cur]++;
                        else if (!on && m_cnt[cur] > 0) m_cnt[cur]--;
                    end
                    if ((g || m_vec[cur] == 0) && m_link[cur] != 0) begin
                        cur = m_link[cur];
                        g = 1;
                    end else begin
                        go = 0;
                    end
                end
            end
        end
    endfunction

    task automatic step(input logic [7:0] lv, input bit ev, input int id,
                        input bit on, input bit grp, input logic [3:0] mk);
        int exp_vec;
        bit any;
        @(negedge clk);
        src_level = lv;
        ev_valid = ev;
        ev_id = 3'(id);
        ev_on = on;
        ev_group = grp;
        imask = mk;
        if (ev) model_event(id, on, grp);
        any = 0;
        exp_vec = 0;
        for (int i = N - 1; i >= 1; i--) begin
            if (lv[i] && m_vec[i] != 0 && m_cnt[i] == m_max[i]) begin
                any = 1;
                exp_vec = m_vec[i];
            end
        end
        @(posedge clk);
        #1;
        ev_valid = 1'b0;
        chk("R2 irq_out", int'(irq_out), int'(any));
        chk("R4 vec_valid", int'(vec_valid), int'(any && mk != 4'hF));
        chk("R3 vec_out", int'(vec_out), (any && mk != 4'hF) ? exp_vec : 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 irq after reset", int'(irq_out), 0);
        chk("R9 valid after reset", int'(vec_valid), 0);
        chk("R9 vec after reset", int'(vec_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: max 0 source is pending on its level alone
        step(8'b0001_0000, 0, 0, 0, 0, 4'h0);
        chk("R1 src4 vec", int'(vec_out), 12'h460);
        // R1: count short of max, not pending
        step(8'b0000_0010, 1, 1, 1, 0, 4'h0);
        chk("R1 src1 partial", int'(irq_out), 0);
        step(8'b0001_0010, 1, 1, 1, 0, 4'h0);
        chk("R3 lowest index wins", int'(vec_out), 12'h400);
        // R6: saturate up, then one down drops it
        step(8'b0000_0010, 1, 1, 1, 0, 4'h0);
        step(8'b0000_0010, 1, 1, 0, 0, 4'h0);
        chk("R6 saturated then disabled", int'(irq_out), 0);
        // R6: saturate down
        step(8'b0000_0010, 1, 1, 0, 0, 4'h0);
        step(8'b0000_0010, 1, 1, 0, 0, 4'h0);
        step(8'b0000_0010, 1, 1, 1, 0, 4'h0);
        chk("R6 floor at zero", int'(irq_out), 0);
        // R7: group head 5 walks to 2 and 3
        step(8'b0000_1100, 1, 5, 1, 0, 4'h0);
        step(8'b0000_1100, 1, 5, 1, 0, 4'h0);
        chk("R7 group enables member", int'(vec_out), 12'h420);
        step(8'b0000_1000, 0, 0, 0, 0, 4'h0);
        chk("R7 group reached second member", int'(vec_out), 12'h440);
        // R7: direct event on 2 does not continue to 3
        step(8'b0000_1000, 1, 2, 0, 0, 4'h0);
        chk("R7 direct stops at member", int'(vec_out), 12'h440);
        // R8: reserved index 6 and index 0 ignored
        step(8'b0000_1000, 1, 6, 0, 1, 4'h0);
        step(8'b0000_1000, 1, 0, 0, 1, 4'h0);
        chk("R8 reserved ignored", int'(vec_out), 12'h440);
        // R4: mask all ones hides vector, irq stays
        step(8'b0000_1000, 0, 0, 0, 0, 4'hF);
        chk("R4 irq kept under mask", int'(irq_out), 1);
        // R5: holding level unchanged keeps outputs
        step(8'b0000_1000, 0, 0, 0, 0, 4'h3);
        step(8'b0000_1000, 0, 0, 0, 0, 4'h3);
        chk("R5 held level stable", int'(vec_out), 12'h440);

        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] lv;
            int r;
            lv = 8'($urandom);
            r = int'($urandom % 8);
            step(lv, ($urandom % 4) != 0, int'($urandom % 8), ($urandom % 2) == 1,
                 ($urandom % 3) == 0, (r == 0) ? 4'hF : 4'($urandom));
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule